// File: doc/BRIEF.md
# Timestamp Capture Latch Bank

This block samples a free-running 64-bit nanosecond time value whenever the transmit or receive data path flags a precision-time event. One latch serves transmit and four independent latches serve receive. A latch keeps its capture and shows a busy flag until software frees it. Software frees a latch by reading that latch's upper time word. A write does not free it.

On a receive event the block picks a free latch in the same cycle and returns its index to the data path. The data path carries that index with the packet so that software can later read that exact latch. If all four receive latches are busy, the event is dropped and counted. The transmit latch raises a maskable interrupt while it holds a capture.

Software reads each capture lower word first. The lower-word read copies the upper half into a per-latch shadow, so the upper word read next belongs to the same capture. All registers are read through a simple read port whose data appears one cycle after the request.

Top module: `stamp_latch_bank`

## Requirements
- R1: After reset every latch is empty, the status and overflow registers read 0, `rd_data` is 0, `tx_irq` is low and `rx_slot_vld` is low.
- R2: A receive event (`rx_evt` high for one cycle) takes the lowest-numbered free receive latch. In that same cycle it raises `rx_slot_vld` with `rx_slot_idx` set to that index. The latch stores the `time_now` value present in the event cycle.
- R3: A receive event while all receive latches are busy gives no valid index and changes no held capture. It adds one to an 8-bit overflow count, read at address 1 and zero-extended, which saturates at 255.
- R4: Reading the upper word of receive latch i (address 5+2i) frees that latch and clears its busy flag. The other latches keep their state.
- R5: Reading the lower word (address 4+2i for receive latch i, address 2 for transmit) returns bits 31:0 of the capture and frees nothing. A later upper-word read (address 5+2i, or 3) returns bits 63:32 of that same capture. Read data appears on `rd_data` one cycle after the cycle with `rd_en` high.
- R6: A transmit event (`tx_evt`) captures `time_now` into the transmit latch only when that latch is empty. A transmit event while it is full leaves the held value unchanged.
- R7: Reading the transmit upper word (address 3) frees the transmit latch.
- R8: `tx_irq` is high exactly when the transmit latch is full and `tx_int_en` is high. Clearing `tx_int_en` masks it.
- R9: The status register at address 0 reads bit 0 = transmit busy, bits 4:1 = receive busy flags for latches 3..0, and bit 5 = a sticky dropped-event flag. Reading the status register clears bit 5.
- R10: A latch freed by a read is not available to an event in that same cycle. A receive event on a full bank in the cycle of an upper-word read is dropped. A transmit event in the cycle of a transmit upper-word read is ignored, and the latch ends empty.
- R11: Reads of addresses 12 to 15 return 0 and change no latch state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current time counter value |
| tx_evt | input | 1 | Transmit timestamp event pulse |
| rx_evt | input | 1 | Receive timestamp event pulse |
| rx_slot_vld | output | 1 | Receive event was given a latch this cycle |
| rx_slot_idx | output | 2 | Index of the latch given to the receive event |
| tx_int_en | input | 1 | Transmit capture interrupt enable |
| tx_irq | output | 1 | Transmit capture interrupt |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, one cycle after request |

## Verification
The risky overlap is a slot being freed by an upper-word read in the very cycle a new event arrives. To provoke it, the bench fills all four receive latches and then raises `rx_evt` together with a read of latch 0's upper word. It expects no valid index in that cycle and a larger overflow count afterwards. It then expects latch 0 to read free in the status register, and a following event to get index 0. The same collision is driven on the transmit side: the event and the transmit upper-word read coincide, and the status register must show the transmit latch empty.

// File: rtl/stl_pkg.sv
package stl_pkg;
  localparam int STL_ADDR_STATUS = 0;
  localparam int STL_ADDR_OVF    = 1;
  localparam int STL_ADDR_TX_LO  = 2;
  localparam int STL_ADDR_TX_HI  = 3;
  localparam int STL_RX_BASE     = 4;
endpackage

// File: rtl/stl_latch.sv
module stl_latch #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_req,
  input  logic [2*WORD_W-1:0] time_in,
  input  logic                rd_lo,
  input  logic                rd_hi,
  output logic                full,
  output logic [WORD_W-1:0]   lo_word,
  output logic [WORD_W-1:0]   hi_shadow
);
  localparam int TIME_W = 2 * WORD_W;

  logic              full_q, full_d;
  logic [TIME_W-1:0] data_q;
  logic [WORD_W-1:0] shd_q;
  logic              cap_en;

  // capture only into an empty latch; a free in this cycle does not count
  assign cap_en = cap_req && !full_q;

  always_comb begin
    full_d = full_q;
    if (rd_hi)  full_d = 1'b0;
    if (cap_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      shd_q  <= '0;
    end else begin
      full_q <= full_d;
      if (cap_en) data_q <= time_in;
      if (rd_lo)  shd_q  <= data_q[TIME_W-1:WORD_W];
    end
  end

  assign full      = full_q;
  assign lo_word   = data_q[WORD_W-1:0];
  assign hi_shadow = shd_q;
endmodule

// File: rtl/stl_alloc.sv
module stl_alloc #(
  parameter int N_SLOT = 4,
  localparam int IDX_W = $clog2(N_SLOT)
) (
  input  logic [N_SLOT-1:0] busy,
  input  logic              req,
  output logic              grant_vld,
  output logic [IDX_W-1:0]  grant_idx,
  output logic [N_SLOT-1:0] grant_vec
);
  always_comb begin
    grant_idx = '0;
    grant_vec = '0;
    // scan downward so the lowest free index is the last one written
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        grant_idx    = IDX_W'(i);
        grant_vec    = '0;
        grant_vec[i] = req;
      end
    end
    grant_vld = req && !(&busy);
  end
endmodule

// File: rtl/stl_rdmux.sv
module stl_rdmux
  import stl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int N_RX   = 4,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           status_w,
  input  logic [WORD_W-1:0]           ovf_w,
  input  logic [WORD_W-1:0]           tx_lo,
  input  logic [WORD_W-1:0]           tx_hi,
  input  logic [N_RX-1:0][WORD_W-1:0] rx_lo,
  input  logic [N_RX-1:0][WORD_W-1:0] rx_hi,
  output logic [WORD_W-1:0]           word
);
  always_comb begin
    word = '0;
    if (addr == ADDR_W'(STL_ADDR_STATUS)) word = status_w;
    if (addr == ADDR_W'(STL_ADDR_OVF))    word = ovf_w;
    if (addr == ADDR_W'(STL_ADDR_TX_LO))  word = tx_lo;
    if (addr == ADDR_W'(STL_ADDR_TX_HI))  word = tx_hi;
    for (int i = 0; i < N_RX; i++) begin
      if (addr == ADDR_W'(STL_RX_BASE + 2*i))     word = rx_lo[i];
      if (addr == ADDR_W'(STL_RX_BASE + 2*i + 1)) word = rx_hi[i];
    end
  end
endmodule

// File: rtl/stamp_latch_bank.sv
module stamp_latch_bank
  import stl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int N_RX   = 4,
  parameter int OVF_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*WORD_W-1:0]       time_now,
  input  logic                      tx_evt,
  input  logic                      rx_evt,
  output logic                      rx_slot_vld,
  output logic [$clog2(N_RX)-1:0]   rx_slot_idx,
  input  logic                      tx_int_en,
  output logic                      tx_irq,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [WORD_W-1:0]         rd_data
);
  localparam int TIME_W = 2 * WORD_W;
  localparam int IDX_W  = $clog2(N_RX);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  logic [N_RX-1:0]             rx_full, rx_cap, rx_lo_rd, rx_hi_rd;
  logic [N_RX-1:0][WORD_W-1:0] rx_lo_w, rx_hi_w;
  logic                        tx_full, tx_lo_rd, tx_hi_rd;
  logic [WORD_W-1:0]           tx_lo_w, tx_hi_w;
  logic                        st_rd, drop;
  logic [OVF_W-1:0]            ovf_q, ovf_d;
  logic                        drop_q, drop_d;
  logic [WORD_W-1:0]           status_w, ovf_w, rd_word, rd_data_q;

  // receive slot allocation, lowest free first
  stl_alloc #(.N_SLOT(N_RX)) u_alloc (
    .busy      (rx_full),
    .req       (rx_evt),
    .grant_vld (rx_slot_vld),
    .grant_idx (rx_slot_idx),
    .grant_vec (rx_cap)
  );

  for (genvar g = 0; g < N_RX; g++) begin : g_rx
    assign rx_lo_rd[g] = rd_en && (rd_addr == ADDR_W'(STL_RX_BASE + 2*g));
    assign rx_hi_rd[g] = rd_en && (rd_addr == ADDR_W'(STL_RX_BASE + 2*g + 1));
    stl_latch #(.WORD_W(WORD_W)) u_lat (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_req   (rx_cap[g]),
      .time_in   (time_now),
      .rd_lo     (rx_lo_rd[g]),
      .rd_hi     (rx_hi_rd[g]),
      .full      (rx_full[g]),
      .lo_word   (rx_lo_w[g]),
      .hi_shadow (rx_hi_w[g])
    );
  end

  assign tx_lo_rd = rd_en && (rd_addr == ADDR_W'(STL_ADDR_TX_LO));
  assign tx_hi_rd = rd_en && (rd_addr == ADDR_W'(STL_ADDR_TX_HI));
  assign st_rd    = rd_en && (rd_addr == ADDR_W'(STL_ADDR_STATUS));

  stl_latch #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_req   (tx_evt),
    .time_in   (time_now),
    .rd_lo     (tx_lo_rd),
    .rd_hi     (tx_hi_rd),
    .full      (tx_full),
    .lo_word   (tx_lo_w),
    .hi_shadow (tx_hi_w)
  );

  assign tx_irq = tx_full && tx_int_en;

  // dropped receive events: saturating count plus sticky flag
  assign drop = rx_evt && (&rx_full);

  always_comb begin
    ovf_d  = ovf_q;
    drop_d = drop_q;
    if (drop && (ovf_q != OVF_MAX)) ovf_d = ovf_q + OVF_W'(1);
    if (st_rd) drop_d = 1'b0;
    if (drop)  drop_d = 1'b1;
  end

  always_comb begin
    status_w             = '0;
    status_w[0]          = tx_full;
    status_w[N_RX:1]     = rx_full;
    status_w[N_RX+1]     = drop_q;
  end

  assign ovf_w = WORD_W'(ovf_q);

  stl_rdmux #(.WORD_W(WORD_W), .N_RX(N_RX), .ADDR_W(ADDR_W)) u_mux (
    .addr     (rd_addr),
    .status_w (status_w),
    .ovf_w    (ovf_w),
    .tx_lo    (tx_lo_w),
    .tx_hi    (tx_hi_w),
    .rx_lo    (rx_lo_w),
    .rx_hi    (rx_hi_w),
    .word     (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q     <= '0;
      drop_q    <= 1'b0;
      rd_data_q <= '0;
    end else begin
      ovf_q  <= ovf_d;
      drop_q <= drop_d;
      if (rd_en) rd_data_q <= rd_word;
    end
  end

  assign rd_data = rd_data_q;

  logic unused_w;
  assign unused_w = ^{TIME_W, IDX_W};
endmodule

// File: rtl/stl_checker.sv
module stl_checker
  import stl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int N_RX   = 4,
  parameter int OVF_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rx_evt,
  input logic [N_RX-1:0]         rx_full,
  input logic                    rx_slot_vld,
  input logic [$clog2(N_RX)-1:0] rx_slot_idx,
  input logic                    tx_full,
  input logic                    tx_int_en,
  input logic                    tx_irq,
  input logic                    rd_en,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic [WORD_W-1:0]       rd_data,
  input logic [OVF_W-1:0]        ovf
);
  localparam logic [OVF_W-1:0]  OVF_TOP  = '1;
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STL_ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_TX_HI  = ADDR_W'(STL_ADDR_TX_HI);
  localparam logic [ADDR_W-1:0] A_RX0_HI = ADDR_W'(STL_RX_BASE + 1);
  localparam int                FIRST_UNMAPPED = STL_RX_BASE + 2*N_RX;

  AST_GRANT_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_slot_vld |-> !rx_full[rx_slot_idx]); // R2
  AST_GRANT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_slot_vld |=> rx_full[$past(rx_slot_idx)]); // R2
  AST_FULL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && (&rx_full)) |-> !rx_slot_vld); // R3
  AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && (&rx_full) && (ovf != OVF_TOP)) |=> (ovf == $past(ovf) + OVF_W'(1))); // R3
  AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf == OVF_TOP) |=> (ovf == OVF_TOP)); // R3
  AST_RX_HI_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == A_RX0_HI) && rx_full[0]) |=> !rx_full[0]); // R10
  AST_TX_HI_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == A_TX_HI) && tx_full) |=> !tx_full); // R7
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !(rd_en && (rd_addr == A_TX_HI))) |=> tx_full); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_int_en |-> !tx_irq); // R8
  AST_IRQ_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_full); // R8
  AST_STATUS_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == A_STATUS)) |=> (rd_data[N_RX:1] == $past(rx_full))); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (int'(rd_addr) >= FIRST_UNMAPPED)) |=> (rd_data == '0)); // R11
endmodule

bind stamp_latch_bank stl_checker #(
  .WORD_W(WORD_W), .N_RX(N_RX), .OVF_W(OVF_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_evt      (rx_evt),
  .rx_full     (rx_full),
  .rx_slot_vld (rx_slot_vld),
  .rx_slot_idx (rx_slot_idx),
  .tx_full     (tx_full),
  .tx_int_en   (tx_int_en),
  .tx_irq      (tx_irq),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .ovf         (ovf_q)
);

// File: tb/stamp_latch_bank_test.sv
module stamp_latch_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk, rst_n;
  logic [63:0] time_now;
  logic        tx_evt, rx_evt, tx_int_en, rd_en;
  logic        rx_slot_vld, tx_irq;
  logic [1:0]  rx_slot_idx;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] held [4];

  stamp_latch_bank uut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .tx_evt(tx_evt), .rx_evt(rx_evt),
    .rx_slot_vld(rx_slot_vld), .rx_slot_idx(rx_slot_idx),
    .tx_int_en(tx_int_en), .tx_irq(tx_irq),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // time advances shortly after each rising edge, stable at the falling edge
  initial time_now = 64'h0000_0A5C_FFFF_FFF0;
  always @(posedge clk) begin
    #2 time_now = time_now + 64'd1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_slot(input int i, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(4'(4 + 2*i), lo);
    rd(4'(5 + 2*i), hi);
    v = {hi, lo};
  endtask

  task automatic rx_pulse(output logic v, output logic [1:0] idx, output logic [63:0] t);
    rx_evt = 1'b1;
    #1;
    v = rx_slot_vld; idx = rx_slot_idx; t = time_now;
    @(negedge clk);
    rx_evt = 1'b0;
  endtask

  task automatic tx_pulse(output logic [63:0] t);
    tx_evt = 1'b1; t = time_now;
    @(negedge clk);
    tx_evt = 1'b0;
  endtask

  task automatic fill_all();
    logic v; logic [1:0] idx; logic [63:0] t;
    for (int i = 0; i < 4; i++) begin
      rx_pulse(v, idx, t);
      held[idx] = t;
    end
  endtask

  task automatic drain_all();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) rd(4'(5 + 2*i), d);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    check("R1 rx_slot_vld", {63'd0, rx_slot_vld}, 64'd0);
    check("R1 tx_irq", {63'd0, tx_irq}, 64'd0);
    check("R1 rd_data", {32'd0, rd_data}, 64'd0);
    rd(4'd0, d); check("R1 status", {32'd0, d}, 64'd0);
    rd(4'd1, d); check("R1 overflow", {32'd0, d}, 64'd0);
  endtask

  task automatic test_rx_alloc();
    logic v; logic [1:0] idx; logic [63:0] t, got; logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      rx_pulse(v, idx, t);
      held[i] = t;
      check("R2 grant valid", {63'd0, v}, 64'd1);
      check("R2 lowest index", {62'd0, idx}, 64'(i));
    end
    rd(4'd0, d); check("R9 all rx busy", {32'd0, d}, 64'h1E);
    rd_slot(2, got); check("R5 slot2 value", got, held[2]);
    rd(4'd0, d); check("R4 slot2 freed only", {32'd0, d}, 64'h16);
    rx_pulse(v, idx, t);
    held[2] = t;
    check("R2 reuse freed slot", {61'd0, v, idx}, 64'b110);
    rd_slot(2, got); check("R2 captured time", got, t);
    rx_pulse(v, idx, t);
    held[2] = t;
  endtask

  task automatic test_rx_drop();
    logic v; logic [1:0] idx; logic [63:0] t, got; logic [31:0] d;
    rx_pulse(v, idx, t);
    check("R3 no grant when full", {63'd0, v}, 64'd0);
    rd(4'd1, d); check("R3 overflow count", {32'd0, d}, 64'd1);
    rd(4'd0, d); check("R9 drop flag set", {32'd0, d}, 64'h3E);
    rd(4'd0, d); check("R9 drop flag cleared by read", {32'd0, d}, 64'h1E);
    rd_slot(0, got); check("R3 held value kept", got, held[0]);
  endtask

  task automatic test_same_cycle();
    logic v; logic [1:0] idx; logic [63:0] t; logic [31:0] d;
    rx_pulse(v, idx, t);
    check("R2 refill slot0", {61'd0, v, idx}, 64'b100);
    rx_evt = 1'b1; rd_en = 1'b1; rd_addr = 4'd5;
    #1;
    check("R10 freed slot not granted same cycle", {63'd0, rx_slot_vld}, 64'd0);
    @(negedge clk);
    rx_evt = 1'b0; rd_en = 1'b0;
    rd(4'd0, d); check("R10 slot0 free after collision", {32'd0, d}, 64'h3C);
    rd(4'd1, d); check("R10 collision counted as drop", {32'd0, d}, 64'd2);
    rx_pulse(v, idx, t);
    check("R10 slot0 granted next", {61'd0, v, idx}, 64'b100);
    drain_all();
    rd(4'd0, d); check("R4 all freed", {32'd0, d}, 64'd0);
  endtask

  task automatic test_tx();
    logic [63:0] t1, t2, t3, t4, got; logic [31:0] d, lo, hi;
    tx_pulse(t1);
    rd(4'd0, d); check("R6 tx busy", {32'd0, d}, 64'd1);
    tx_int_en = 1'b1; #1;
    check("R8 irq on", {63'd0, tx_irq}, 64'd1);
    tx_int_en = 1'b0; #1;
    check("R8 irq masked", {63'd0, tx_irq}, 64'd0);
    @(negedge clk);
    tx_pulse(t2);
    rd(4'd2, lo); rd(4'd3, hi);
    check("R6 first capture kept", {hi, lo}, t1);
    rd(4'd0, d); check("R7 tx freed", {32'd0, d}, 64'd0);
    tx_pulse(t3);
    tx_evt = 1'b1; rd_en = 1'b1; rd_addr = 4'd3;
    @(negedge clk);
    tx_evt = 1'b0; rd_en = 1'b0;
    rd(4'd0, d); check("R10 tx event ignored on free cycle", {32'd0, d}, 64'd0);
    tx_pulse(t4);
    tx_int_en = 1'b1; #1;
    check("R8 irq after new capture", {63'd0, tx_irq}, 64'd1);
    tx_int_en = 1'b0;
    @(negedge clk);
    rd(4'd2, lo);
    repeat (20) @(negedge clk);
    rd(4'd0, d); check("R5 low read frees nothing", {32'd0, d}, 64'd1);
    rd(4'd3, hi);
    check("R5 tx low/high pair", {hi, lo}, t4);
    got = t3;
  endtask

  task automatic test_unmapped();
    logic v; logic [1:0] idx; logic [63:0] t, got; logic [31:0] d;
    rx_pulse(v, idx, t);
    rd(4'd12, d); check("R11 addr 12 reads zero", {32'd0, d}, 64'd0);
    rd(4'd15, d); check("R11 addr 15 reads zero", {32'd0, d}, 64'd0);
    rd(4'd0, d); check("R11 state untouched", {32'd0, d}, 64'h02);
    rd_slot(0, got); check("R11 capture untouched", got, t);
  endtask

  task automatic test_saturate();
    logic v; logic [1:0] idx; logic [63:0] t; logic [31:0] d;
    int grants = 0;
    fill_all();
    for (int i = 0; i < 300; i++) begin
      rx_pulse(v, idx, t);
      if (v) grants++;
    end
    check("R3 no grants while full", 64'(grants), 64'd0);
    rd(4'd1, d); check("R3 overflow saturates", {32'd0, d}, 64'd255);
    drain_all();
  endtask

  initial begin
    rst_n = 1'b0; tx_evt = 1'b0; rx_evt = 1'b0; tx_int_en = 1'b0;
    rd_en = 1'b0; rd_addr = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_rx_alloc();
    test_rx_drop();
    test_same_cycle();
    test_tx();
    test_unmapped();
    test_saturate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule